// File: doc/BRIEF.md
# Privileged Control Register File

This block holds the processor-internal control registers that privileged firmware reads and writes by index. Each request is a single command on one port: a valid bit, a direction bit, a 6-bit index and a 64-bit write value. The block answers one clock later with read data, a write acknowledge, or an access error. Every register trims the bits of a write with its own keep-mask. Two registers clear to zero whatever value is written to them. Three registers are read-only and six are write-only. Three of the write-only locations store nothing and instead raise a one-cycle invalidate strobe for the translation buffers, with the written value as the operand.

A free-running 32-bit cycle counter runs alongside the register bank. A read of the cycle register returns its stored upper half joined to the live counter value. An illegal access changes no state and raises the error output for one cycle. Illegal accesses are a write to a read-only index, a read from a write-only index, and any access to an index of 32 or above.

The response side is a small state machine with the states IDLE, WACK, RDATA, FAULT, INV_ALL, INV_PROC and INV_ONE. After each cycle it moves to exactly one of these:
- FAULT when the request is illegal.
- RDATA when the request is a legal read.
- INV_ALL, INV_PROC or INV_ONE when the request writes index 29, 30 or 31.
- WACK for any other legal write.
- IDLE when there is no request.

The state alone drives every response output.

Top module: `ctlreg_file`

## Requirements
- R1: After reset every register reads zero, except index 5, which reads 0x6, and index 4, which reads the parameter VEC_BASE_RST. All response outputs are low after reset.
- R2: Indices 0 to 6 keep all 64 written bits. A legal read returns rsp_rvalid with the data in the next cycle. A legal write returns rsp_wack in the next cycle.
- R3: A read of index 6 returns bits [63:32] from the stored value and bits [31:0] from the cycle counter as sampled in the cycle of the request.
- R4: The cycle counter is 32 bits wide. Reset clears it, it adds one every clock, and it wraps on overflow.
- R5: The keep-masks are 0x1f for index 7, 0xf for indices 8 and 9, 0x18 for indices 10 and 11, 0x7fff0 for index 12, and 0xffffff0300 for index 13.
- R6: Indices 14 and 15 keep bits [63:30]. Indices 16 and 17 keep 0x3f. Index 18 keeps 0x7f0. Index 19 keeps bits [63:57]. Index 20 keeps 0x1ffb.
- R7: A write of any value to index 21 or 22 leaves that register reading zero. The write is acknowledged.
- R8: A write to read-only index 23, 24 or 25 raises rsp_err for one cycle, gives no acknowledge, and changes no register.
- R9: A read of write-only index 26 to 31 raises rsp_err for one cycle, gives no rsp_rvalid, and leaves rsp_rdata unchanged.
- R10: Any read or write to an index of 32 to 63 raises rsp_err and changes no register.
- R11: A write to index 29, 30 or 31 pulses inv_all, inv_proc or inv_one for one cycle, with inv_operand equal to the written value. The write is acknowledged and stores nothing.
- R12: A write to index 26, 27 or 28 is acknowledged without error and has no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_idx | input | IDX_W | Register index |
| req_wdata | input | 64 | Write value |
| rsp_rvalid | output | 1 | Read data valid (one cycle after request) |
| rsp_rdata | output | 64 | Read data, held until the next legal read |
| rsp_wack | output | 1 | Legal write accepted |
| rsp_err | output | 1 | Illegal access flagged |
| inv_all | output | 1 | Invalidate-all strobe |
| inv_proc | output | 1 | Invalidate-process strobe |
| inv_one | output | 1 | Invalidate-single strobe |
| inv_operand | output | 64 | Value written with the last strobe |

## Verification
The masking logic is driven with all-ones, alternating 0x55 and 0xAA patterns, and zeros to every masked index. Together these patterns separate a wrong keep-mask from a stuck bit or a swapped index. The cycle register is read back-to-back and with idle gaps in between. This shows whether the low half follows the live counter and whether the high half keeps the stored value. Illegal accesses are interleaved with full read-back sweeps, so an error path that writes anyway shows up as a changed register. Reads of the write-only indices check that rsp_rdata keeps its last legal value.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;

    localparam int DATA_W   = 64;
    localparam int NUM_REGS = 32;

    localparam int IX_VEC      = 4;
    localparam int IX_MISC     = 5;
    localparam int IX_CYC      = 6;
    localparam int IX_PRIO     = 7;
    localparam int IX_EXCSUM   = 21;
    localparam int IX_EXCMSK   = 22;
    localparam int IX_INV_ALL  = 29;
    localparam int IX_INV_PROC = 30;
    localparam int IX_INV_ONE  = 31;

    localparam logic [DATA_W-1:0] MISC_RST = 64'h6;

    typedef enum logic [2:0] {
        ACC_STORE,
        ACC_CLEAR,
        ACC_RO,
        ACC_WO,
        ACC_STROBE,
        ACC_NONE
    } acc_kind_e;

    typedef enum logic [1:0] {
        INV_NONE,
        INV_ALL,
        INV_PROC,
        INV_ONE
    } inv_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WACK,
        ST_RDATA,
        ST_FAULT,
        ST_INV_ALL,
        ST_INV_PROC,
        ST_INV_ONE
    } rsp_state_e;

    function automatic acc_kind_e kind_of(input int id);
        if (id < 0)  return ACC_NONE;
        if (id <= 20) return ACC_STORE;
        if (id <= 22) return ACC_CLEAR;
        if (id <= 25) return ACC_RO;
        if (id <= 28) return ACC_WO;
        if (id <= 31) return ACC_STROBE;
        return ACC_NONE;
    endfunction

    // Bits a write is allowed to set; zero for clear-on-write and read-only.
    function automatic logic [DATA_W-1:0] wr_mask(input int id);
        case (id)
            0, 1, 2, 3, 4, 5, 6: return '1;
            7:                   return 64'h1f;
            8, 9:                return 64'hf;
            10, 11:              return 64'h18;
            12:                  return 64'h7fff0;
            13:                  return 64'hff_ffff_0300;
            14, 15:              return 64'hffff_ffff_c000_0000;
            16, 17:              return 64'h3f;
            18:                  return 64'h7f0;
            19:                  return 64'hfe00_0000_0000_0000;
            20:                  return 64'h1ffb;
            default:             return '0;
        endcase
    endfunction

    function automatic inv_kind_e inv_of(input int id);
        case (id)
            IX_INV_ALL:  return INV_ALL;
            IX_INV_PROC: return INV_PROC;
            IX_INV_ONE:  return INV_ONE;
            default:     return INV_NONE;
        endcase
    endfunction

endpackage

// File: rtl/ctlreg_cycctr.sv
module ctlreg_cycctr #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + CNT_W'(1);
    end

    // R4: one step per clock, modulo 2^CNT_W
    a_r4_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cnt == $past(cnt) + CNT_W'(1)));

endmodule

// File: rtl/ctlreg_decode.sv
module ctlreg_decode
    import ctlreg_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [IDX_W-1:0] req_idx,
    output logic             illegal,
    output logic             store_en,
    output logic             read_ok,
    output inv_kind_e        inv_kind
);

    localparam int ID_W = $clog2(NUM_REGS);

    logic            mapped;
    logic [ID_W-1:0] id;
    acc_kind_e       kind;

    assign mapped = (req_idx[IDX_W-1:ID_W] == '0);
    assign id     = req_idx[ID_W-1:0];
    assign kind   = kind_of(int'(id));

    always_comb begin
        illegal  = 1'b0;
        store_en = 1'b0;
        read_ok  = 1'b0;
        inv_kind = INV_NONE;
        if (req_valid) begin
            if (!mapped) begin
                illegal = 1'b1;
            end else if (req_write) begin
                unique case (kind)
                    ACC_STORE, ACC_CLEAR: store_en = 1'b1;
                    ACC_RO:               illegal  = 1'b1;
                    ACC_WO:               ;
                    ACC_STROBE:           inv_kind = inv_of(int'(id));
                    default:              illegal  = 1'b1;
                endcase
            end else begin
                if (kind == ACC_WO || kind == ACC_STROBE || kind == ACC_NONE)
                    illegal = 1'b1;
                else
                    read_ok = 1'b1;
            end
        end
    end

endmodule

// File: rtl/ctlreg_store.sv
module ctlreg_store
    import ctlreg_pkg::*;
#(
    parameter int                CNT_W        = 32,
    parameter logic [DATA_W-1:0] VEC_BASE_RST = 64'h0000_0000_0001_c000
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [$clog2(NUM_REGS)-1:0]     wr_id,
    input  logic [DATA_W-1:0]               wr_data,
    input  logic [$clog2(NUM_REGS)-1:0]     rd_id,
    input  logic [CNT_W-1:0]                cnt,
    output logic [DATA_W-1:0]               rd_word
);

    localparam int ID_W = $clog2(NUM_REGS);

    logic [DATA_W-1:0] regs [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam acc_kind_e K = kind_of(g);
        if (K == ACC_STORE || K == ACC_CLEAR || K == ACC_RO) begin : g_held
            localparam logic [DATA_W-1:0] KEEP = wr_mask(g);
            localparam logic [DATA_W-1:0] RV   = (g == IX_VEC)  ? VEC_BASE_RST :
                                                 (g == IX_MISC) ? MISC_RST : '0;
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                            q <= RV;
                else if (wr_en && wr_id == ID_W'(g))   q <= wr_data & KEEP;
            end
            assign regs[g] = q;
        end else begin : g_none
            assign regs[g] = '0;
        end
    end

    assign rd_word = (rd_id == ID_W'(IX_CYC)) ? {regs[IX_CYC][DATA_W-1:CNT_W], cnt}
                                              : regs[rd_id];

    // R5: priority level never holds bits above [4:0]
    a_r5_prio_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        regs[IX_PRIO][DATA_W-1:5] == '0);

    // R7: clear-on-write registers stay zero
    a_r7_clear_regs_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (regs[IX_EXCSUM] == '0) && (regs[IX_EXCMSK] == '0));

endmodule

// File: rtl/ctlreg_file.sv
module ctlreg_file
    import ctlreg_pkg::*;
#(
    parameter int          IDX_W        = 6,
    parameter int          CNT_W        = 32,
    parameter logic [63:0] VEC_BASE_RST = 64'h0000_0000_0001_c000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [IDX_W-1:0] req_idx,
    input  logic [63:0]      req_wdata,
    output logic             rsp_rvalid,
    output logic [63:0]      rsp_rdata,
    output logic             rsp_wack,
    output logic             rsp_err,
    output logic             inv_all,
    output logic             inv_proc,
    output logic             inv_one,
    output logic [63:0]      inv_operand
);

    localparam int ID_W = $clog2(NUM_REGS);

    logic              dec_illegal;
    logic              dec_store;
    logic              dec_read_ok;
    inv_kind_e         dec_inv;
    logic [CNT_W-1:0]  cyc_cnt;
    logic [63:0]       rd_word;
    logic [ID_W-1:0]   acc_id;
    rsp_state_e        state_q, state_d;
    logic [63:0]       rdata_q;
    logic [63:0]       operand_q;

    assign acc_id = req_idx[ID_W-1:0];

    ctlreg_decode #(.IDX_W(IDX_W)) u_decode (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_idx   (req_idx),
        .illegal   (dec_illegal),
        .store_en  (dec_store),
        .read_ok   (dec_read_ok),
        .inv_kind  (dec_inv)
    );

    ctlreg_cycctr #(.CNT_W(CNT_W)) u_cycctr (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt   (cyc_cnt)
    );

    ctlreg_store #(.CNT_W(CNT_W), .VEC_BASE_RST(VEC_BASE_RST)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (dec_store),
        .wr_id   (acc_id),
        .wr_data (req_wdata),
        .rd_id   (acc_id),
        .cnt     (cyc_cnt),
        .rd_word (rd_word)
    );

    // Next-state selection
    always_comb begin
        if (dec_illegal)                  state_d = ST_FAULT;
        else if (dec_read_ok)             state_d = ST_RDATA;
        else if (dec_inv == INV_ALL)      state_d = ST_INV_ALL;
        else if (dec_inv == INV_PROC)     state_d = ST_INV_PROC;
        else if (dec_inv == INV_ONE)      state_d = ST_INV_ONE;
        else if (req_valid && req_write)  state_d = ST_WACK;
        else                              state_d = ST_IDLE;
    end

    // State register and response data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            rdata_q   <= '0;
            operand_q <= '0;
        end else begin
            state_q <= state_d;
            if (dec_read_ok)         rdata_q   <= rd_word;
            if (dec_inv != INV_NONE) operand_q <= req_wdata;
        end
    end

    // Outputs from state
    always_comb begin
        rsp_rvalid = 1'b0;
        rsp_wack   = 1'b0;
        rsp_err    = 1'b0;
        inv_all    = 1'b0;
        inv_proc   = 1'b0;
        inv_one    = 1'b0;
        unique case (state_q)
            ST_IDLE:     ;
            ST_WACK:     rsp_wack = 1'b1;
            ST_RDATA:    rsp_rvalid = 1'b1;
            ST_FAULT:    rsp_err = 1'b1;
            ST_INV_ALL:  begin rsp_wack = 1'b1; inv_all  = 1'b1; end
            ST_INV_PROC: begin rsp_wack = 1'b1; inv_proc = 1'b1; end
            ST_INV_ONE:  begin rsp_wack = 1'b1; inv_one  = 1'b1; end
            default:     ;
        endcase
    end

    assign rsp_rdata   = rdata_q;
    assign inv_operand = operand_q;

    // R8 / R10: an illegal request is answered by the error flag
    a_r8_fault_on_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && dec_illegal) |=> (rsp_err && !rsp_wack && !rsp_rvalid));

    // R9: an error response never disturbs the held read data
    a_r9_err_keeps_rdata: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> $stable(rsp_rdata));

    // R11: strobes only follow a write request, and never more than one
    a_r11_strobe_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_all || inv_proc || inv_one) |-> $past(req_valid && req_write));

    a_r11_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({inv_all, inv_proc, inv_one}));

endmodule

// File: tb/ctlreg_file_tb_top.sv
`timescale 1ns/1ps
module ctlreg_file_tb_top;

    localparam logic [63:0] VB = 64'h0000_0000_0003_8000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [5:0]  req_idx = '0;
    logic [63:0] req_wdata = '0;
    logic        rsp_rvalid, rsp_wack, rsp_err, inv_all, inv_proc, inv_one;
    logic [63:0] rsp_rdata, inv_operand;

    always #2.5 clk = ~clk;

    ctlreg_file #(.IDX_W(6), .CNT_W(32), .VEC_BASE_RST(VB)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_idx(req_idx), .req_wdata(req_wdata),
        .rsp_rvalid(rsp_rvalid), .rsp_rdata(rsp_rdata),
        .rsp_wack(rsp_wack), .rsp_err(rsp_err),
        .inv_all(inv_all), .inv_proc(inv_proc), .inv_one(inv_one),
        .inv_operand(inv_operand)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    string tag = "R1";

    logic [63:0] mdl [32];
    logic [31:0] mcnt;
    logic e_rv, e_wa, e_err, e_ia, e_ip, e_io;
    logic [63:0] e_rd, e_op;

    function automatic logic [63:0] keep_bits(int i);
        if (i <= 6) return {64{1'b1}};
        case (i)
            7:       return 64'd31;
            8, 9:    return 64'd15;
            10, 11:  return 64'd24;
            12:      return 64'h7fff0;
            13:      return 64'hff_ffff_0300;
            14, 15:  return ~((64'd1 << 30) - 64'd1);
            16, 17:  return 64'd63;
            18:      return 64'h7f0;
            19:      return ~((64'd1 << 57) - 64'd1);
            20:      return 64'h1ffb;
            default: return 64'd0;
        endcase
    endfunction

    task automatic chk1(string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk1("rvalid", {63'd0, rsp_rvalid}, {63'd0, e_rv});
        chk1("rdata", rsp_rdata, e_rd);
        chk1("wack", {63'd0, rsp_wack}, {63'd0, e_wa});
        chk1("err", {63'd0, rsp_err}, {63'd0, e_err});
        chk1("strobes", {61'd0, inv_all, inv_proc, inv_one}, {61'd0, e_ia, e_ip, e_io});
        if (e_ia || e_ip || e_io) chk1("operand", inv_operand, e_op);
    endtask

    // Drive one request (or idle) at a falling edge, compare at the next one.
    task automatic cycle(string t, bit v, bit w, int idx, logic [63:0] d);
        req_valid = v; req_write = w; req_idx = 6'(idx); req_wdata = d;
        e_rv = 0; e_wa = 0; e_err = 0; e_ia = 0; e_ip = 0; e_io = 0;
        if (v) begin
            if (idx >= 32) e_err = 1;
            else if (w) begin
                if (idx >= 23 && idx <= 25) e_err = 1;
                else begin
                    e_wa = 1;
                    if (idx <= 22) mdl[idx] = d & keep_bits(idx);
                    if (idx == 29) begin e_ia = 1; e_op = d; end
                    if (idx == 30) begin e_ip = 1; e_op = d; end
                    if (idx == 31) begin e_io = 1; e_op = d; end
                end
            end else begin
                if (idx >= 26) e_err = 1;
                else begin
                    e_rv = 1;
                    e_rd = (idx == 6) ? {mdl[6][63:32], mcnt} : mdl[idx];
                end
            end
        end
        @(posedge clk);
        mcnt = mcnt + 32'd1;
        @(negedge clk);
        req_valid = 0;
        tag = t;
        compare_all();
    endtask

    initial begin
        for (int i = 0; i < 32; i++) mdl[i] = '0;
        mdl[4] = VB;
        mdl[5] = 64'h6;
        e_rv = 0; e_wa = 0; e_err = 0; e_ia = 0; e_ip = 0; e_io = 0;
        e_rd = '0; e_op = '0;
        mcnt = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        tag = "R1";
        compare_all();

        // R1: reset values
        for (int i = 0; i < 26; i++) cycle("R1", 1, 0, i, '0);

        // R2: full-width registers
        for (int i = 0; i < 6; i++) begin
            cycle("R2", 1, 1, i, 64'ha5a5_0f0f_3c3c_9696 ^ 64'(i));
            cycle("R2", 1, 0, i, '0);
            cycle("R2", 1, 1, i, ~(64'h1234_5678_9abc_def0 + 64'(i)));
            cycle("R2", 0, 0, 0, '0);
            cycle("R2", 1, 0, i, '0);
        end

        // R3: stored upper half, live lower half
        cycle("R3", 1, 1, 6, 64'hdead_beef_1234_5678);
        repeat (3) cycle("R3", 0, 0, 0, '0);
        cycle("R3", 1, 0, 6, '0);
        repeat (7) cycle("R3", 0, 0, 0, '0);
        cycle("R3", 1, 0, 6, '0);

        // R4: counter steps by one per clock
        repeat (4) cycle("R4", 1, 0, 6, '0);

        // R5, R6: masked registers
        for (int i = 7; i <= 20; i++) begin
            string t;
            t = (i <= 13) ? "R5" : "R6";
            cycle(t, 1, 1, i, {64{1'b1}});
            cycle(t, 1, 0, i, '0);
            cycle(t, 1, 1, i, {32{2'b01}});
            cycle(t, 1, 0, i, '0);
            cycle(t, 1, 1, i, {32{2'b10}});
            cycle(t, 1, 0, i, '0);
        end

        // R7: clear on write
        cycle("R7", 1, 1, 21, {64{1'b1}});
        cycle("R7", 1, 0, 21, '0);
        cycle("R7", 1, 1, 22, 64'h8000_0000_0000_0001);
        cycle("R7", 1, 0, 22, '0);

        // R8: writes to read-only indices
        for (int i = 23; i <= 25; i++) begin
            cycle("R8", 1, 1, i, {64{1'b1}});
            cycle("R8", 1, 0, i, '0);
        end
        for (int i = 0; i <= 20; i++) cycle("R8", 1, 0, i, '0);

        // R9: reads of write-only indices keep old read data
        cycle("R9", 1, 0, 4, '0);
        for (int i = 26; i <= 31; i++) cycle("R9", 1, 0, i, '0);

        // R10: unmapped indices
        cycle("R10", 1, 0, 32, '0);
        cycle("R10", 1, 0, 45, '0);
        cycle("R10", 1, 1, 40, {64{1'b1}});
        cycle("R10", 1, 1, 63, 64'h0123_4567_89ab_cdef);
        cycle("R10", 1, 1, 32, 64'h5);
        for (int i = 0; i < 8; i++) cycle("R10", 1, 0, i, '0);

        // R11: invalidate strobes
        cycle("R11", 1, 1, 29, 64'h1111_2222_3333_4444);
        cycle("R11", 1, 1, 30, 64'h5555_6666_7777_8888);
        cycle("R11", 0, 0, 0, '0);
        cycle("R11", 1, 1, 31, 64'h9999_aaaa_bbbb_cccc);
        cycle("R11", 1, 1, 29, 64'h0);
        cycle("R11", 0, 0, 0, '0);

        // R12: plain write-only indices
        for (int i = 26; i <= 28; i++) cycle("R12", 1, 1, i, {64{1'b1}});
        for (int i = 0; i <= 22; i++) cycle("R12", 1, 0, i, '0);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule